// File: doc/BRIEF.md
# Memory-Mapped 16-bit Timer Peripheral

A 16-bit timer that sits on a simple peripheral bus and serves as a time-stamp or interval source for software. Software programs a control register to pick one of four clock-enable sources, a prescale ratio of 1, 2, 4 or 8, and one of four count behaviours. In continuous mode the counter free-runs and wraps through zero. In up mode it runs to a compare value and then returns to zero. In up/down mode it runs up to the compare value and then back down to zero. Every return to zero sets an overflow flag, and that flag drives an interrupt line when software enables it.

Software can stop the counter, which holds both the count and the prescaler state, and then restart it. It can clear the count, the prescaler and the direction in a single write, or load the counter directly. The interrupt source register reports a pending overflow with a code and consumes it on read, so an interrupt handler needs one access to both identify and acknowledge the event. Clock sources arrive as single-cycle enable pulses in the block's own clock domain.

Top module: `tmr16_periph`

## Requirements
- R1: After reset the control, counter, compare and source registers all read 0, and the interrupt output is 0.
- R2: Register addresses are: control 0x0160, counter 0x0170, interrupt source 0x012E and compare 0x0172. Control bits 9:8 hold the source, bits 7:6 the prescale, bits 5:4 the mode, bit 1 the interrupt enable and bit 0 the overflow flag. Bits 15:10, 3 and 2 read as 0.
- R3: The source field picks which enable input advances the timer: 00 the external pulse, 01 the auxiliary pulse, 10 the system pulse, 11 the inverted-external pulse. Pulses on the other inputs have no effect on the count.
- R4: The prescale field 00/01/10/11 makes the counter advance once per 1/2/4/8 pulses of the selected source.
- R5: Mode 10 counts up continuously. A step from 0xFFFF goes to 0 and sets the overflow flag.
- R6: Mode 01 counts up to the compare value. The next step returns the count to 0 and sets the overflow flag.
- R7: Mode 11 counts up to the compare value and then down. The step that reaches 0 sets the overflow flag, and counting then proceeds upward again.
- R8: Mode 00 holds the count and the prescaler state. Restarting resumes from the held prescaler phase.
- R9: Writing control with bit 2 set zeroes the count, the prescaler and the direction (the next up/down step goes up). The new field values take effect in the same write, and bit 2 is not stored.
- R10: A bus write to the counter loads the written value and overrides any count step in the same cycle.
- R11: Reading the source register returns 0x000A when the flag is set and 0x0000 otherwise, and it clears the flag. An overflow in the same cycle as that read leaves the flag set.
- R12: The interrupt output is 1 exactly when both the overflow flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 16 | Read data; 0 when no read is strobed or the address is not decoded |
| clk_ext_en | input | 1 | External clock enable pulse (source 00) |
| clk_aux_en | input | 1 | Auxiliary clock enable pulse (source 01) |
| clk_sys_en | input | 1 | System clock enable pulse (source 10) |
| clk_ext_n_en | input | 1 | Inverted external clock enable pulse (source 11) |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: the 16-bit counter and the four default register addresses. Preloading the counter just below 0xFFFF makes the continuous-mode wrap reachable in two source pulses. Small compare values bring the up-mode return and both up/down turning points within a few pulses, including the case where the direction is cleared while counting down. Because the bench drives each source pulse one at a time, the prescaler phase across stop, restart and clear can be counted exactly.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;

  localparam int unsigned TMR_W     = 16;
  localparam int unsigned N_SRC     = 4;
  localparam int unsigned SRC_SEL_W = $clog2(N_SRC);
  localparam int unsigned DIV_SEL_W = 2;
  localparam int unsigned DIV_CNT_W = (2 ** DIV_SEL_W) - 1;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [SRC_SEL_W-1:0] src;
    logic [DIV_SEL_W-1:0] div;
    tmr_mode_e            mode;
    logic                 ie;
  } tmr_ctrl_t;

  typedef struct packed {
    logic [TMR_W-1:0] cnt;
    logic             down;
    logic             wrap;
  } cnt_step_t;

  // last prescaler phase before a counter step: divide ratio minus one
  function automatic logic [DIV_CNT_W-1:0] div_limit(input logic [DIV_SEL_W-1:0] sel);
    logic [DIV_CNT_W-1:0] lim;
    lim = '0;
    for (int i = 0; i < DIV_CNT_W; i++) begin
      if (i < int'(sel)) lim[i] = 1'b1;
    end
    return lim;
  endfunction

  // one counting step of the selected mode
  function automatic cnt_step_t count_next(input tmr_mode_e mode,
                                           input logic [TMR_W-1:0] cur,
                                           input logic [TMR_W-1:0] cmp,
                                           input logic down);
    cnt_step_t r;
    r.cnt  = cur;
    r.down = down;
    r.wrap = 1'b0;
    case (mode)
      MODE_UP: begin
        if (cur >= cmp) begin
          r.cnt  = '0;
          r.wrap = 1'b1;
        end else begin
          r.cnt = cur + 1'b1;
        end
      end
      MODE_CONT: begin
        r.cnt  = cur + 1'b1;
        r.wrap = &cur;
      end
      MODE_UPDN: begin
        if (!down && (cur < cmp)) begin
          r.cnt = cur + 1'b1;
        end else if (cur <= TMR_W'(1)) begin
          r.cnt  = '0;
          r.down = 1'b0;
          r.wrap = 1'b1;
        end else begin
          r.cnt  = cur - 1'b1;
          r.down = 1'b1;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

  // control register as seen by a bus read
  function automatic logic [TMR_W-1:0] ctrl_view(input tmr_ctrl_t c, input logic flag);
    logic [TMR_W-1:0] v;
    v      = '0;
    v[9:8] = c.src;
    v[7:6] = c.div;
    v[5:4] = c.mode;
    v[1]   = c.ie;
    v[0]   = flag;
    return v;
  endfunction

endpackage

// File: rtl/tmr16_srcsel.sv
`timescale 1ns/1ps
module tmr16_srcsel
  import tmr16_pkg::*;
(
  input  logic [N_SRC-1:0]     src_en,
  input  logic [SRC_SEL_W-1:0] sel,
  output logic                 src_tick
);

  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src_en[g] && (sel == SRC_SEL_W'(g));
  end

  assign src_tick = |hit;

endmodule

// File: rtl/tmr16_prescale.sv
`timescale 1ns/1ps
module tmr16_prescale
  import tmr16_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 clr,
  input  logic                 src_tick,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 cnt_tick
);

  logic [DIV_CNT_W-1:0] phase_q;
  logic                 at_lim;

  assign at_lim   = phase_q >= div_limit(div_sel);
  assign cnt_tick = run && src_tick && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clr) begin
      phase_q <= '0;
    end else if (run && src_tick) begin
      phase_q <= at_lim ? '0 : phase_q + 1'b1;
    end
  end

  // R8: a stopped timer keeps its prescaler phase
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> (phase_q == $past(phase_q)));

  // R9: a clear leaves the prescaler at its first phase
  assert_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == '0));

endmodule

// File: rtl/tmr16_counter.sv
`timescale 1ns/1ps
module tmr16_counter
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic [TMR_W-1:0] cmp,
  input  logic             step,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             clr,
  output logic [TMR_W-1:0] cnt,
  output logic             wrap_evt
);

  logic      down_q;
  logic      adv;
  cnt_step_t nx;

  assign adv = step && !load && !clr;

  always_comb nx = count_next(mode, cnt, cmp, down_q);

  assign wrap_evt = adv && nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
    end else if (adv) begin
      cnt    <= nx.cnt;
      down_q <= nx.down;
    end
  end

  // R6: every overflow event leaves the count at zero
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));

  // R8: without a step, load or clear the count holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load && !clr) |=> (cnt == $past(cnt)));

  // R10: a bus load wins over a step in the same cycle
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt == $past(load_val)));

  // R9: a clear zeroes the count and the direction
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !down_q));

endmodule

// File: rtl/tmr16_periph.sv
`timescale 1ns/1ps
module tmr16_periph
  import tmr16_pkg::*;
#(
  parameter logic [15:0] ADDR_CTRL = 16'h0160,
  parameter logic [15:0] ADDR_CNT  = 16'h0170,
  parameter logic [15:0] ADDR_VEC  = 16'h012E,
  parameter logic [15:0] ADDR_CMP  = 16'h0172,
  parameter logic [15:0] OVF_CODE  = 16'h000A
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic [TMR_W-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [TMR_W-1:0] bus_rdata,
  input  logic             clk_ext_en,
  input  logic             clk_aux_en,
  input  logic             clk_sys_en,
  input  logic             clk_ext_n_en,
  output logic             ovf_irq
);

  localparam int unsigned CLR_BIT = 2;

  tmr_ctrl_t        ctrl_q;
  logic             flag_q;
  logic [TMR_W-1:0] cmp_q;

  // bus decode
  logic wr_ctrl, wr_cnt, wr_cmp, rd_vec, clr_req;
  assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_cnt  = bus_we && (bus_addr == ADDR_CNT);
  assign wr_cmp  = bus_we && (bus_addr == ADDR_CMP);
  assign rd_vec  = bus_re && (bus_addr == ADDR_VEC);
  assign clr_req = wr_ctrl && bus_wdata[CLR_BIT];

  // timing chain
  logic [N_SRC-1:0] src_en;
  logic             src_tick, cnt_tick, run, wrap_evt;
  logic [TMR_W-1:0] cnt_val;

  assign src_en = {clk_ext_n_en, clk_sys_en, clk_aux_en, clk_ext_en};
  assign run    = (ctrl_q.mode != MODE_STOP);

  tmr16_srcsel u_srcsel (
    .src_en   (src_en),
    .sel      (ctrl_q.src),
    .src_tick (src_tick)
  );

  tmr16_prescale u_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (clr_req),
    .src_tick (src_tick),
    .div_sel  (ctrl_q.div),
    .cnt_tick (cnt_tick)
  );

  tmr16_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (ctrl_q.mode),
    .cmp      (cmp_q),
    .step     (cnt_tick),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .clr      (clr_req),
    .cnt      (cnt_val),
    .wrap_evt (wrap_evt)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{src: '0, div: '0, mode: MODE_STOP, ie: 1'b0};
    end else if (wr_ctrl) begin
      ctrl_q.src  <= bus_wdata[9:8];
      ctrl_q.div  <= bus_wdata[7:6];
      ctrl_q.mode <= tmr_mode_e'(bus_wdata[5:4]);
      ctrl_q.ie   <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wrap_evt) begin
      flag_q <= 1'b1;
    end else if (rd_vec) begin
      flag_q <= 1'b0;
    end else if (wr_ctrl) begin
      flag_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp) begin
      cmp_q <= bus_wdata;
    end
  end

  assign ovf_irq = flag_q && ctrl_q.ie;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata = ctrl_view(ctrl_q, flag_q);
        ADDR_CNT:  bus_rdata = cnt_val;
        ADDR_CMP:  bus_rdata = cmp_q;
        ADDR_VEC:  bus_rdata = flag_q ? OVF_CODE : '0;
        default:   bus_rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[15:10], bus_wdata[3]};

  // R5: an overflow event always leaves the flag set
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);

  // R11: a source read without a coincident overflow consumes the flag
  assert_vec_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !wrap_evt) |=> !flag_q);

  // R12: the request never rises without the enable
  assert_irq_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_irq) |-> ctrl_q.ie);

endmodule

// File: tb/sim_tmr16_periph.sv
`timescale 1ns/1ps
module sim_tmr16_periph;

  localparam logic [15:0] A_CTRL = 16'h0160;
  localparam logic [15:0] A_CNT  = 16'h0170;
  localparam logic [15:0] A_VEC  = 16'h012E;
  localparam logic [15:0] A_CMP  = 16'h0172;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [3:0]  pl = '0;   // 0 ext, 1 aux, 2 sys, 3 inverted ext
  logic        ovf_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  tmr16_periph u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_rdata    (bus_rdata),
    .clk_ext_en   (pl[0]),
    .clk_aux_en   (pl[1]),
    .clk_sys_en   (pl[2]),
    .clk_ext_n_en (pl[3]),
    .ovf_irq      (ovf_irq)
  );

  // ---------------- reference model ----------------
  int m_cnt, m_cmp, m_src, m_div, m_mode, m_ph;
  bit m_ie, m_ifg, m_down;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_src = 0; m_div = 0; m_mode = 0; m_ph = 0;
      m_ie = 0; m_ifg = 0; m_down = 0;
    end else begin
      int nc, nph;
      bit ndown, ev, tk, step;
      tk = pl[m_src];
      nph = m_ph; step = 0;
      if (m_mode != 0 && tk) begin
        if (m_ph >= (1 << m_div) - 1) begin step = 1; nph = 0; end
        else nph = m_ph + 1;
      end
      nc = m_cnt; ndown = m_down; ev = 0;
      if (step) begin
        if (m_mode == 1) begin
          if (m_cnt >= m_cmp) begin nc = 0; ev = 1; end else nc = m_cnt + 1;
        end else if (m_mode == 2) begin
          if (m_cnt == 65535) begin nc = 0; ev = 1; end else nc = m_cnt + 1;
        end else if (m_mode == 3) begin
          if (!m_down && m_cnt < m_cmp) nc = m_cnt + 1;
          else if (m_cnt <= 1) begin nc = 0; ndown = 0; ev = 1; end
          else begin nc = m_cnt - 1; ndown = 1; end
        end
      end
      if (bus_we && bus_addr == A_CNT) begin nc = bus_wdata; ev = 0; end
      if (bus_we && bus_addr == A_CMP) m_cmp = bus_wdata;
      if (bus_we && bus_addr == A_CTRL) begin
        if (bus_wdata[2]) begin nc = 0; nph = 0; ndown = 0; ev = 0; end
        m_src = bus_wdata[9:8]; m_div = bus_wdata[7:6]; m_mode = bus_wdata[5:4];
        m_ie = bus_wdata[1]; m_ifg = bus_wdata[0];
      end
      if (bus_re && bus_addr == A_VEC) m_ifg = 0;
      if (ev) m_ifg = 1;
      m_cnt = nc; m_ph = nph; m_down = ndown;
    end
  end

  function automatic logic [15:0] m_read();
    logic [15:0] v;
    v = '0;
    if (bus_re) begin
      if (bus_addr == A_CTRL) begin
        v[9:8] = 2'(m_src); v[7:6] = 2'(m_div); v[5:4] = 2'(m_mode);
        v[1] = m_ie; v[0] = m_ifg;
      end else if (bus_addr == A_CNT) v = 16'(m_cnt);
      else if (bus_addr == A_CMP) v = 16'(m_cmp);
      else if (bus_addr == A_VEC) v = m_ifg ? 16'h000A : 16'h0000;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 irq vs model", {15'b0, ovf_irq}, {15'b0, m_ie & m_ifg});
      if (bus_addr == A_CTRL)     chk("R2 ctrl read vs model", bus_rdata, m_read());
      else if (bus_addr == A_CNT) chk("R5 count read vs model", bus_rdata, m_read());
      else if (bus_addr == A_VEC) chk("R11 source read vs model", bus_rdata, m_read());
      else                        chk("R6 compare read vs model", bus_rdata, m_read());
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic begin_cyc();
    @(negedge clk);
    #1;
    bus_we = 0; bus_re = 0; pl = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin_cyc();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    begin_cyc();
    bus_addr = a; bus_wdata = d; bus_we = 1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    begin_cyc();
    bus_addr = a; bus_re = 1;
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      begin_cyc();
      pl[idx] = 1'b1;
    end
  endtask

  task automatic wr_pulse(input logic [15:0] a, input logic [15:0] d, input int idx);
    begin_cyc();
    bus_addr = a; bus_wdata = d; bus_we = 1; pl[idx] = 1'b1;
  endtask

  task automatic rd_pulse(input logic [15:0] a, input logic [15:0] exp, input int idx, input string tag);
    begin_cyc();
    bus_addr = a; bus_re = 1; pl[idx] = 1'b1;
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    begin_cyc();
    #2;
    chk(tag, {15'b0, ovf_irq}, {15'b0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_CTRL, 16'h0000, "R1 ctrl after reset");
    rd(A_CNT,  16'h0000, "R1 count after reset");
    rd(A_VEC,  16'h0000, "R1 source after reset");
    rd(A_CMP,  16'h0000, "R1 compare after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R2 field layout and reserved bits
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, 16'h03F3, "R2 ctrl readback of all-ones");
    chk_irq(1'b1, "R12 irq with flag and enable");
    wr(A_CTRL, 16'h0000);
    rd(A_CTRL, 16'h0000, "R2 ctrl readback of zero");

    // R3 source selection
    wr(A_CTRL, 16'h0124);
    pulse(0, 5); pulse(2, 5); pulse(3, 5);
    rd(A_CNT, 16'd0, "R3 aux selected ignores others");
    pulse(1, 4);
    rd(A_CNT, 16'd4, "R3 aux pulses counted");
    wr(A_CTRL, 16'h0024);
    pulse(1, 3); pulse(0, 3);
    rd(A_CNT, 16'd3, "R3 ext selected");
    wr(A_CTRL, 16'h0324);
    pulse(0, 2); pulse(3, 2);
    rd(A_CNT, 16'd2, "R3 inverted ext selected");
    wr(A_CTRL, 16'h0224);
    pulse(2, 6);
    rd(A_CNT, 16'd6, "R3 sys selected");

    // R4 prescaler ratios
    wr(A_CTRL, 16'h02A4); pulse(2, 10);
    rd(A_CNT, 16'd2, "R4 divide by 4");
    wr(A_CTRL, 16'h02E4); pulse(2, 17);
    rd(A_CNT, 16'd2, "R4 divide by 8");
    wr(A_CTRL, 16'h0264); pulse(2, 5);
    rd(A_CNT, 16'd2, "R4 divide by 2");

    // R8 stop holds count and prescaler phase
    wr(A_CTRL, 16'h02A4); pulse(2, 2);
    wr(A_CTRL, 16'h0280); pulse(2, 5);
    rd(A_CNT, 16'd0, "R8 stopped count holds");
    wr(A_CTRL, 16'h02A0); pulse(2, 2);
    rd(A_CNT, 16'd1, "R8 resume keeps prescaler phase");

    // R9 clear resets count and prescaler
    pulse(2, 2);
    wr(A_CTRL, 16'h02A4); pulse(2, 3);
    rd(A_CNT, 16'd0, "R9 prescaler restarted by clear");
    pulse(2, 1);
    rd(A_CNT, 16'd1, "R9 first step after clear");
    rd(A_CTRL, 16'h02A0, "R9 clear bit reads zero");

    // R5 continuous wrap, R11 and R12
    wr(A_CTRL, 16'h0224);
    wr(A_CNT, 16'hFFFE);
    pulse(2, 2);
    rd(A_CNT, 16'h0000, "R5 wrap to zero");
    rd(A_CTRL, 16'h0221, "R5 flag set on wrap");
    chk_irq(1'b0, "R12 irq masked when disabled");
    wr(A_CTRL, 16'h0223);
    chk_irq(1'b1, "R12 irq when enabled");
    rd(A_VEC, 16'h000A, "R11 pending code");
    rd(A_VEC, 16'h0000, "R11 cleared by read");
    chk_irq(1'b0, "R12 irq drops after acknowledge");
    rd(A_CTRL, 16'h0222, "R11 flag clear in ctrl");

    // R6 up mode
    wr(A_CMP, 16'd3);
    rd(A_CMP, 16'd3, "R2 compare readback");
    wr(A_CTRL, 16'h0214);
    pulse(2, 3);
    rd(A_CNT, 16'd3, "R6 reaches compare");
    rd(A_CTRL, 16'h0210, "R6 no flag at compare");
    pulse(2, 1);
    rd(A_CNT, 16'd0, "R6 returns to zero");
    rd(A_CTRL, 16'h0211, "R6 flag on return");
    pulse(2, 2);
    rd(A_CNT, 16'd2, "R6 counts again");

    // R7 up/down
    wr(A_CMP, 16'd2);
    wr(A_CTRL, 16'h0234);
    pulse(2, 2);
    rd(A_CNT, 16'd2, "R7 top reached");
    pulse(2, 1);
    rd(A_CNT, 16'd1, "R7 counting down");
    rd(A_CTRL, 16'h0230, "R7 no flag at top");
    pulse(2, 1);
    rd(A_CNT, 16'd0, "R7 bottom reached");
    rd(A_CTRL, 16'h0231, "R7 flag at zero");
    pulse(2, 1);
    rd(A_CNT, 16'd1, "R7 up again after zero");
    pulse(2, 2);
    wr(A_CTRL, 16'h0234);
    pulse(2, 1);
    rd(A_CNT, 16'd1, "R9 clear resets direction");

    // R10 counter load beats a step
    wr(A_CTRL, 16'h0224);
    pulse(2, 3);
    wr_pulse(A_CNT, 16'h1234, 2);
    rd(A_CNT, 16'h1234, "R10 load overrides step");
    pulse(2, 1);
    rd(A_CNT, 16'h1235, "R10 counts from loaded value");

    // R11 overflow coinciding with an acknowledge keeps the flag
    wr(A_CTRL, 16'h0221);
    wr(A_CNT, 16'hFFFF);
    rd_pulse(A_VEC, 16'h000A, 2, "R11 code during coincident wrap");
    rd(A_CTRL, 16'h0221, "R11 set wins over read clear");
    rd(A_CNT, 16'h0000, "R5 wrap during read");
    rd(A_VEC, 16'h000A, "R11 still pending");
    rd(A_VEC, 16'h0000, "R11 nothing pending");

    idle(3);
    finish_run();
  end

endmodule